// File: doc/BRIEF.md
# Sound Control Register Bank with Power Gating

This block holds the byte-wide control registers of a four-channel sound unit and sits on a simple 8-bit CPU I/O port. The port has one address, a write strobe, write data and a combinational read-data path. Inside a 32-byte window, the channel registers sit at fixed indices. Channel 1 uses indices 0..4, channel 2 uses 5..9, channel 3 uses 10..14 and channel 4 uses 15..19. Master volume is at 20, panning at 21 and the master control byte at 22.

Reads OR a per-register mask into the stored byte, so that bits which are unused or write-only read as 1. The master power bit gates CPU writes. While power is off, channel-register writes store zero, with two exceptions. The duty/length registers still forward their low six bits. In legacy mode, the channel-3 and channel-4 length registers still accept writes.

Every accepted write leaves the block as a one-cycle event carrying the index, the data and a one-hot channel select, so the channel logic can act on it. The event is a valid-only stream with no back-pressure: a receiver must take it in the cycle it is shown, and one event follows each accepted write exactly one clock later.

Top module: `snd_regfile`

## Requirements
- R1: While power is off, a write to any channel register other than the exceptions in R2 and R3 leaves the stored byte 0 and produces no event.
- R2: While power is off and `legacy_mode` is 1, writes to the channel-3 length register (index 11) and the channel-4 length register (index 16) are stored and produce an event carrying the full written byte. With `legacy_mode` 0, the same writes produce no event.
- R3: While power is off, a write to a duty/length register (index 1 or 6) produces an event whose data is the written byte AND 0x3F, and the stored byte stays 0.
- R4: A write to master control (index 22) keeps only bit 7, the power bit. A read of master control returns {power, 3'b111, ch_active[3:0]}.
- R5: Read masks are ORed into the stored byte:
  - sweep (0): 0x80
  - duty/length (1, 6): 0x3F
  - frequency-high/trigger (4, 9, 14, 19): 0xBF
  - wave DAC enable (10): 0x7F
  - wave level (12): 0x9F
  - master control: 0x70
  - frequency-low (3, 8, 13) and length registers (11, 16): always read 0xFF
- R6: Envelope registers (2, 7, 17), the polynomial register (18), master volume (20) and panning (21) read back exactly as stored.
- R7: After reset, power is on, master volume stores 0x77, panning stores 0xF3, sweep stores 0x80, and every other register stores 0.
- R8: Each accepted write produces `evt_valid` for exactly one cycle, one clock after the write. The event carries the index, the data and a one-hot `evt_chan` (bit n for indices 5n..5n+4, and none for indices 20..22).
- R9: Writing master control with bit 7 = 0 while power is on clears every channel, volume and panning register to 0 at that same clock edge.
- R10: Indices 5, 15 and 23..31 are unmapped. They read 0xFF, and writes to them produce no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | Selects the length-register write exception |
| bus_addr | input | 5 | Register index for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| ch_active | input | 4 | Live channel-active flags |
| power_on | output | 1 | Master power bit |
| evt_valid | output | 1 | One-cycle write event |
| evt_idx | output | 5 | Register index of the event |
| evt_data | output | 8 | Data forwarded to the channel |
| evt_chan | output | 4 | One-hot channel select of the event |

## Verification
The bench builds the block with its default parameters: a 5-bit index, 8-bit registers and four channels. This reaches every mapped index, both gap slots and the unmapped tail above index 22. With this build, the bench can walk the full mask table, toggle power in both directions, and exercise the length exception with `legacy_mode` both low and high. Power-off behaviour is observed through read-back and through the presence or absence of events.

// File: rtl/snd_pkg.sv
package snd_pkg;
  localparam int REG_W       = 8;
  localparam int ADDR_W      = 5;
  localparam int NUM_CH      = 4;
  localparam int REGS_PER_CH = 5;
  localparam int NUM_REGS    = NUM_CH * REGS_PER_CH + 3;

  localparam int IDX_SWEEP  = 0;
  localparam int IDX_DUTY1  = 1;
  localparam int IDX_GAP2   = 5;
  localparam int IDX_DUTY2  = 6;
  localparam int IDX_LEN3   = 11;
  localparam int IDX_GAP4   = 15;
  localparam int IDX_LEN4   = 16;
  localparam int IDX_VOL    = NUM_CH * REGS_PER_CH;
  localparam int IDX_PAN    = IDX_VOL + 1;
  localparam int IDX_MASTER = IDX_VOL + 2;

  typedef logic [REG_W-1:0] byte_t;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] idx;
    byte_t             val;
  } wr_t;

  function automatic logic is_mapped(input int idx);
    return (idx < NUM_REGS) && (idx != IDX_GAP2) && (idx != IDX_GAP4);
  endfunction

  function automatic byte_t rd_mask(input int idx);
    case (idx)
      0:                 return 8'h80;
      1, 6:              return 8'h3F;
      2, 7, 17, 18:      return 8'h00;
      4, 9, 14, 19:      return 8'hBF;
      10:                return 8'h7F;
      12:                return 8'h9F;
      IDX_VOL, IDX_PAN:  return 8'h00;
      IDX_MASTER:        return 8'h70;
      default:           return 8'hFF;
    endcase
  endfunction

  function automatic byte_t rst_val(input int idx);
    case (idx)
      IDX_SWEEP: return 8'h80;
      IDX_VOL:   return 8'h77;
      IDX_PAN:   return 8'hF3;
      default:   return 8'h00;
    endcase
  endfunction

  function automatic logic [NUM_CH-1:0] chan_of(input int idx);
    logic [NUM_CH-1:0] r;
    r = '0;
    if (idx < NUM_CH * REGS_PER_CH) r[idx / REGS_PER_CH] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/snd_wr_gate.sv
module snd_wr_gate
  import snd_pkg::*;
(
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  byte_t             bus_wdata,
  input  logic              power_on,
  input  logic              legacy_mode,
  output wr_t               store,
  output wr_t               evt,
  output logic              pwr_wr,
  output logic              pwr_drop
);
  logic hit, is_master, is_len_exc, is_duty;

  always_comb begin
    hit        = bus_wr && is_mapped(int'(bus_addr));
    is_master  = int'(bus_addr) == IDX_MASTER;
    is_len_exc = legacy_mode &&
                 (int'(bus_addr) == IDX_LEN3 || int'(bus_addr) == IDX_LEN4);
    is_duty    = int'(bus_addr) == IDX_DUTY1 || int'(bus_addr) == IDX_DUTY2;

    store      = '0;
    evt        = '0;
    store.idx  = bus_addr;
    evt.idx    = bus_addr;
    pwr_wr     = hit && is_master;
    pwr_drop   = pwr_wr && power_on && !bus_wdata[REG_W-1];

    if (hit && is_master) begin
      evt.en  = 1'b1;
      evt.val = bus_wdata;
    end else if (hit) begin
      store.en = 1'b1;
      if (power_on || is_len_exc) begin
        store.val = bus_wdata;
        evt.en    = 1'b1;
        evt.val   = bus_wdata;
      end else if (is_duty) begin
        store.val = '0;
        evt.en    = 1'b1;
        evt.val   = bus_wdata & 8'h3F;
      end else begin
        store.val = '0;
      end
    end
  end
endmodule

// File: rtl/snd_reg_bank.sv
module snd_reg_bank
  import snd_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  wr_t                           store,
  input  logic                          pwr_drop,
  input  logic                          power_on,
  output logic [IDX_MASTER-1:0][REG_W-1:0] q
);
  for (genvar i = 0; i < IDX_MASTER; i++) begin : g_reg
    if (is_mapped(i)) begin : g_flop
      always_ff @(posedge clk) begin
        if (rst)                                        q[i] <= rst_val(i);
        else if (pwr_drop)                              q[i] <= '0;
        else if (store.en && int'(store.idx) == i)      q[i] <= store.val;
      end
      if (i != IDX_LEN3 && i != IDX_LEN4) begin : g_chk
        assert_off_zero_R9: assert property (@(posedge clk) disable iff (rst)
          !power_on |-> q[i] == '0);
      end
    end else begin : g_gap
      assign q[i] = '0;
    end
  end
endmodule

// File: rtl/snd_rd_mux.sv
module snd_rd_mux
  import snd_pkg::*;
(
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic [IDX_MASTER-1:0][REG_W-1:0] q,
  input  logic                             power_on,
  input  logic [NUM_CH-1:0]                ch_active,
  output byte_t                            bus_rdata
);
  always_comb begin
    if (!is_mapped(int'(bus_addr)))
      bus_rdata = 8'hFF;
    else if (int'(bus_addr) == IDX_MASTER)
      bus_rdata = {power_on, 3'b000, ch_active} | rd_mask(IDX_MASTER);
    else
      bus_rdata = q[bus_addr] | rd_mask(int'(bus_addr));
  end
endmodule

// File: rtl/snd_regfile.sv
module snd_regfile
  import snd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              legacy_mode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [NUM_CH-1:0] ch_active,
  output logic              power_on,
  output logic              evt_valid,
  output logic [ADDR_W-1:0] evt_idx,
  output logic [REG_W-1:0]  evt_data,
  output logic [NUM_CH-1:0] evt_chan
);
  wr_t  store, evt;
  logic pwr_wr, pwr_drop;
  logic [IDX_MASTER-1:0][REG_W-1:0] q;

  snd_wr_gate u_gate (
    .bus_wr, .bus_addr, .bus_wdata, .power_on, .legacy_mode,
    .store, .evt, .pwr_wr, .pwr_drop
  );

  snd_reg_bank u_bank (
    .clk, .rst, .store, .pwr_drop, .power_on, .q
  );

  snd_rd_mux u_rd (
    .bus_addr, .q, .power_on, .ch_active, .bus_rdata
  );

  always_ff @(posedge clk) begin
    if (rst)         power_on <= 1'b1;
    else if (pwr_wr) power_on <= bus_wdata[REG_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_valid <= 1'b0;
      evt_idx   <= '0;
      evt_data  <= '0;
      evt_chan  <= '0;
    end else begin
      evt_valid <= evt.en;
      evt_idx   <= evt.idx;
      evt_data  <= evt.val;
      evt_chan  <= evt.en ? chan_of(int'(evt.idx)) : '0;
    end
  end

  assert_evt_needs_write_R8: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> $past(bus_wr));

  assert_evt_chan_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(evt_chan) && (!evt_valid -> evt_chan == '0));

  assert_power_follows_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && int'(bus_addr) == IDX_MASTER) |=> power_on == $past(bus_wdata[REG_W-1]));

  assert_duty_low6_R3: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !power_on &&
     (int'(evt_idx) == IDX_DUTY1 || int'(evt_idx) == IDX_DUTY2))
      |-> evt_data[7:6] == 2'b00);
endmodule

// File: tb/tb_snd_regfile.sv
module tb_snd_regfile;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       legacy_mode = 1'b0;
  logic [4:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] ch_active = 4'b0101;
  logic       power_on, evt_valid;
  logic [4:0] evt_idx;
  logic [7:0] evt_data;
  logic [3:0] evt_chan;

  int total = 0, bad = 0, cycles = 0;

  always #10 clk = ~clk;

  snd_regfile dut (
    .clk, .rst, .legacy_mode, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata,
    .ch_active, .power_on, .evt_valid, .evt_idx, .evt_data, .evt_chan
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // write one byte; afterwards sits at the negedge where the event is visible
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic evt_chk(input string req, input logic v, input logic [4:0] i,
                         input logic [7:0] d, input logic [3:0] ch);
    check(req, {27'd0, evt_valid}, {31'd0, v});
    if (v) begin
      check(req, {27'd0, evt_idx}, {27'd0, i});
      check(req, {24'd0, evt_data}, {24'd0, d});
      check(req, {28'd0, evt_chan}, {28'd0, ch});
    end
  endtask

  task automatic t_reset;
    rd_chk("R7 master", 5'd22, 8'hF5);
    check("R7 power", {31'd0, power_on}, 32'd1);
    rd_chk("R7 vol", 5'd20, 8'h77);
    rd_chk("R7 pan", 5'd21, 8'hF3);
    rd_chk("R7 sweep", 5'd0, 8'h80);
    rd_chk("R7 env", 5'd2, 8'h00);
    check("R7 evt idle", {31'd0, evt_valid}, 32'd0);
  endtask

  task automatic t_masks;
    logic [7:0] m [20];
    m = '{8'h80, 8'h3F, 8'h00, 8'hFF, 8'hBF, 8'hFF, 8'h3F, 8'h00, 8'hFF, 8'hBF,
          8'h7F, 8'hFF, 8'h9F, 8'hFF, 8'hBF, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'hBF};
    for (int i = 0; i < 20; i++) begin
      wr(5'(i), 8'h5A);
      rd_chk((m[i] == 8'h00) ? "R6 nomask" : "R5 mask", 5'(i),
             (i == 5 || i == 15) ? 8'hFF : (8'h5A | m[i]));
    end
    wr(5'd20, 8'h21); rd_chk("R6 vol", 5'd20, 8'h21);
    wr(5'd21, 8'h9C); rd_chk("R6 pan", 5'd21, 8'h9C);
    wr(5'd2, 8'hC3);  rd_chk("R6 env", 5'd2, 8'hC3);
  endtask

  task automatic t_events;
    wr(5'd12, 8'hA5);
    evt_chk("R8 evt ch3", 1'b1, 5'd12, 8'hA5, 4'b0100);
    @(negedge clk);
    evt_chk("R8 one cycle", 1'b0, '0, '0, '0);
    wr(5'd20, 8'h33);
    evt_chk("R8 evt mixer", 1'b1, 5'd20, 8'h33, 4'b0000);
    wr(5'd17, 8'h11);
    evt_chk("R8 evt ch4", 1'b1, 5'd17, 8'h11, 4'b1000);
  endtask

  task automatic t_unmapped;
    rd_chk("R10 rd 5", 5'd5, 8'hFF);
    rd_chk("R10 rd 15", 5'd15, 8'hFF);
    rd_chk("R10 rd 23", 5'd23, 8'hFF);
    rd_chk("R10 rd 31", 5'd31, 8'hFF);
    wr(5'd27, 8'h00);
    evt_chk("R10 no evt", 1'b0, '0, '0, '0);
    wr(5'd15, 8'h00);
    evt_chk("R10 no evt gap", 1'b0, '0, '0, '0);
  endtask

  task automatic t_master;
    wr(5'd22, 8'h8F);
    evt_chk("R4 evt", 1'b1, 5'd22, 8'h8F, 4'b0000);
    rd_chk("R4 rd", 5'd22, 8'hF5);
    ch_active = 4'b1010;
    rd_chk("R4 live flags", 5'd22, 8'hFA);
  endtask

  task automatic t_power_off;
    wr(5'd7, 8'h3C);
    wr(5'd22, 8'h7F);
    check("R4 off", {31'd0, power_on}, 32'd0);
    rd_chk("R4 rd off", 5'd22, 8'h7A);
    rd_chk("R9 env cleared", 5'd7, 8'h00);
    rd_chk("R9 vol cleared", 5'd20, 8'h00);
    rd_chk("R9 pan cleared", 5'd21, 8'h00);
    wr(5'd7, 8'h55);
    evt_chk("R1 no evt", 1'b0, '0, '0, '0);
    rd_chk("R1 env stays 0", 5'd7, 8'h00);
    wr(5'd20, 8'h66);
    rd_chk("R1 vol stays 0", 5'd20, 8'h00);
  endtask

  task automatic t_duty;
    wr(5'd1, 8'hFF);
    evt_chk("R3 duty1 evt", 1'b1, 5'd1, 8'h3F, 4'b0001);
    rd_chk("R3 duty1 rd", 5'd1, 8'h3F);
    wr(5'd6, 8'hC5);
    evt_chk("R3 duty2 evt", 1'b1, 5'd6, 8'h05, 4'b0010);
  endtask

  task automatic t_legacy;
    legacy_mode = 1'b0;
    wr(5'd16, 8'h12);
    evt_chk("R2 off no evt", 1'b0, '0, '0, '0);
    wr(5'd11, 8'h34);
    evt_chk("R2 off no evt ch3", 1'b0, '0, '0, '0);
    legacy_mode = 1'b1;
    wr(5'd16, 8'h12);
    evt_chk("R2 legacy ch4", 1'b1, 5'd16, 8'h12, 4'b1000);
    wr(5'd11, 8'hE4);
    evt_chk("R2 legacy ch3", 1'b1, 5'd11, 8'hE4, 4'b0100);
    wr(5'd12, 8'h60);
    evt_chk("R2 other blocked", 1'b0, '0, '0, '0);
    legacy_mode = 1'b0;
  endtask

  task automatic t_power_on;
    wr(5'd22, 8'h80);
    check("R4 on", {31'd0, power_on}, 32'd1);
    wr(5'd7, 8'h44);
    rd_chk("R1 writes resume", 5'd7, 8'h44);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_masks;
    t_events;
    t_unmapped;
    t_master;
    t_power_off;
    t_duty;
    t_legacy;
    t_power_on;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule